// File: doc/BRIEF.md
# Overlay Plane Scaler Address Generator

This block walks the output raster of a video overlay plane and, for every output pixel, names the source pixel and source line to fetch together with the fractional position between neighbouring source samples. Each axis has a fixed-point accumulator that moves forward by a step equal to source size over destination size. The integer part of the accumulator is the source index, and its upper fraction bits are the phase that a later filter stage would use. Filter coefficients and pixel arithmetic live outside this block.

Software places three configuration words and two mode bits on the inputs. A frame-start strobe latches them, and a line-start strobe opens each output line. After a line starts, the block advances one output pixel per clock. It raises its valid output only for pixels inside the programmed output window. Only upscaling is accepted, up to five times per axis. An axis whose source and destination sizes are equal is passed through unscaled. With interlaced output, every field covers half the destination lines, and the bottom field begins half a vertical step lower than the top field.

Top module: `scl_phase_gen`

## Requirements
- R1: On a scaled axis the step is floor(src * 2^24 / dst) and fits 28 bits. For the output sample k positions into the window, the accumulator is init + k*step. The index output is the accumulator shifted right by 24, clamped to src-1. The phase output is accumulator bits 23:16.
- R2: An axis is rejected when its destination size (the full, unhalved height for the vertical axis) is smaller than its source size or larger than five times its source size. A rejected configuration sets cfg_err to 1, and pix_valid then stays 0 for the whole frame.
- R3: When source and destination sizes of an axis are equal, that axis's scale-enable output is 0, its phase is 0 and its index equals the offset into the window. When the sizes differ, the scale-enable output is 1.
- R4: in_size holds width-1 in bits 28:16 and height-1 in bits 12:0. Each window word holds an inclusive end in bits 27:16 and a start in bits 11:0. Any other bit set, or an end below its start, sets cfg_err. All configuration is captured only at a frame-start strobe.
- R5: With interlace set, the vertical window start becomes start/2, the exclusive end becomes (end+1)/2, and the field height is their difference. A field height of 0 sets cfg_err.
- R6: In an interlaced bottom field on a scaled vertical axis, the initial vertical accumulator is step/2. The top field and the horizontal axis start at 0. In progressive mode the bottom-field input has no effect.
- R7: A line-start strobe restarts the pixel count at 0 and the horizontal accumulator at its initial value. The horizontal accumulator advances after each in-window pixel. The vertical accumulator restarts at frame start and advances at each line start that ends an in-window line.
- R8: pix_valid is 1 only after a line start of the current frame, with the pixel and line counts inside the inclusive window bounds and no configuration error.
- R9: A frame-start and a line-start strobe in the same cycle make that cycle open line 0 of the new frame, which uses the new configuration.
- R10: After reset, pix_valid and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Frame (field) start strobe; latches configuration |
| line_start | input | 1 | Output line start strobe |
| interlace | input | 1 | Interlaced output mode, latched at frame start |
| fld_bottom | input | 1 | Next field is the bottom field, latched at frame start |
| in_size | input | 32 | Source size word (width-1 at 28:16, height-1 at 12:0) |
| win_h | input | 32 | Horizontal output window (end 27:16, start 11:0) |
| win_v | input | 32 | Vertical output window (end 27:16, start 11:0) |
| pix_valid | output | 1 | Current output pixel lies inside the window |
| src_x | output | 13 | Source pixel index |
| src_y | output | 13 | Source line index |
| phase_x | output | 8 | Horizontal fractional phase |
| phase_y | output | 8 | Vertical fractional phase |
| h_scale_en | output | 1 | Horizontal axis is scaling |
| v_scale_en | output | 1 | Vertical axis is scaling |
| cfg_err | output | 1 | Latched configuration rejected |

## Verification
Frame start and line start can arrive in the same cycle. In that case the restart of the vertical accumulator and the line count must not be undone by the line-start advance, and the new configuration must be used for line 0 at once. The bench issues a frame with both strobes in one cycle and one with a gap between them, using the same configuration. A scoreboard expects the identical raster of indices and phases from both. An extra or missing line shows up as a displaced vertical index or as leftover queue entries.

// File: rtl/scl_pkg.sv
// Shared constants and helpers for the scaler address generator.
// Assumes 32-bit configuration words whose fields sit at bit 0 and bit 16.
package scl_pkg;
    localparam int CFG_W  = 32;
    localparam int HI_LSB = 16;
    localparam int LO_LSB = 0;

    // Mask of the legal bits of a word that carries two fields of width w.
    function automatic logic [CFG_W-1:0] field_mask(input int w);
        logic [CFG_W-1:0] one_fld;
        one_fld = CFG_W'((64'd1 << w) - 64'd1);
        return (one_fld << HI_LSB) | (one_fld << LO_LSB);
    endfunction

    // Axis index used by the per-axis generate loop.
    localparam int AX_H = 0;
    localparam int AX_V = 1;
    localparam int N_AX = 2;
endpackage

// File: rtl/scl_step_calc.sv
// Per-axis step and range calculator.
// Computes src/dst as a fixed-point step with FRAC_W fraction bits.
// Forces exactly 1.0 when the sizes match, and tests the upscale range.
// Assumes the inputs are static for a frame (driven from latched state).
module scl_step_calc #(
    parameter int SZ_W   = 13,
    parameter int FRAC_W = 24,
    parameter int STEP_W = 28,
    parameter int MAX_UP = 5
) (
    input  logic [SZ_W-1:0]   src_len,
    input  logic [SZ_W-1:0]   dst_len,
    input  logic [SZ_W-1:0]   chk_len,
    output logic [STEP_W-1:0] step,
    output logic              scale_en,
    output logic              range_ok
);
    localparam int NUM_W = SZ_W + FRAC_W;
    localparam int LIM_W = SZ_W + 4;
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(64'd1 << FRAC_W);

    logic [NUM_W-1:0]  num;
    logic [NUM_W-1:0]  den;
    logic [STEP_W-1:0] quo;
    logic [LIM_W-1:0]  up_lim;

    // Fixed-point quotient with a guard against an empty destination.
    always_comb begin
        num = {src_len, {FRAC_W{1'b0}}};
        den = (dst_len == '0) ? NUM_W'(1) : NUM_W'(dst_len);
        quo = STEP_W'(num / den);
    end

    // Bypass selection and upscale range test.
    always_comb begin
        scale_en = (src_len != dst_len);
        step     = scale_en ? quo : STEP_ONE;
        up_lim   = LIM_W'(src_len) * LIM_W'(MAX_UP);
        range_ok = (dst_len != '0) && (chk_len >= src_len) &&
                   (LIM_W'(chk_len) <= up_lim);
    end
endmodule

// File: rtl/scl_axis_acc.sv
// Per-axis phase accumulator.
// Holds the running sum of steps since the last clear. The initial phase is
// added on the read side, so a clear never needs the new initial value.
// Assumes step <= 2.0 and at most 2^SZ_W advances between clears.
module scl_axis_acc #(
    parameter int SZ_W   = 13,
    parameter int FRAC_W = 24,
    parameter int STEP_W = 28,
    parameter int PH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] init,
    input  logic [SZ_W-1:0]   src_len,
    output logic [SZ_W-1:0]   idx,
    output logic [PH_W-1:0]   phase
);
    localparam int ACC_W = SZ_W + FRAC_W + 2;
    localparam int INT_W = ACC_W - FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] eff;
    logic [INT_W-1:0] int_part;
    logic [INT_W-1:0] last;

    // Accumulate steps; a clear wins over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clr)    acc <= '0;
        else if (adv)    acc <= acc + ACC_W'(step);
    end

    // Apply the initial phase, clamp the index and take the top fraction bits.
    always_comb begin
        eff      = acc + ACC_W'(init);
        int_part = eff[ACC_W-1:FRAC_W];
        last     = INT_W'(src_len) - INT_W'(1);
        idx      = (int_part > last) ? SZ_W'(last) : SZ_W'(int_part);
        phase    = PH_W'(eff[FRAC_W-1:0] >> (FRAC_W - PH_W));
    end

    // R7
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R1
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (acc - $past(acc) == ACC_W'($past(step))));
endmodule

// File: rtl/scl_phase_gen.sv
// Scaler address generator for one overlay plane.
// Latches the configuration at frame start, decodes the window and sizes,
// and drives one step calculator and one accumulator per axis.
// Walks the output raster one pixel per clock after each line start.
// Assumes line starts are spaced longer than the window width.
module scl_phase_gen
    import scl_pkg::*;
#(
    parameter int SZ_W   = 13,
    parameter int CRD_W  = 12,
    parameter int FRAC_W = 24,
    parameter int STEP_W = 28,
    parameter int PH_W   = 8,
    parameter int MAX_UP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             interlace,
    input  logic             fld_bottom,
    input  logic [CFG_W-1:0] in_size,
    input  logic [CFG_W-1:0] win_h,
    input  logic [CFG_W-1:0] win_v,
    output logic             pix_valid,
    output logic [SZ_W-1:0]  src_x,
    output logic [SZ_W-1:0]  src_y,
    output logic [PH_W-1:0]  phase_x,
    output logic [PH_W-1:0]  phase_y,
    output logic             h_scale_en,
    output logic             v_scale_en,
    output logic             cfg_err
);
    localparam logic [CFG_W-1:0] SIZE_MASK = field_mask(SZ_W);
    localparam logic [CFG_W-1:0] WIN_MASK  = field_mask(CRD_W);

    // Latched configuration
    logic [CFG_W-1:0] size_q, wh_q, wv_q;
    logic             il_q, bot_q;

    // Raster state
    logic             line_active;
    logic [SZ_W-1:0]  x_cnt, y_cnt;

    // Decoded geometry
    logic [SZ_W-1:0]  src_w, src_h, hs, he, vs, ve;
    logic [SZ_W-1:0]  dst_w, dst_hf, vs_f, ve_p1, vend_p1, dst_he, ve_f;
    logic             rsv_bad, order_bad, in_h, in_v;

    // Per-axis wiring
    logic [SZ_W-1:0]   ax_src [N_AX];
    logic [SZ_W-1:0]   ax_dst [N_AX];
    logic [SZ_W-1:0]   ax_chk [N_AX];
    logic [STEP_W-1:0] ax_step[N_AX];
    logic [STEP_W-1:0] ax_init[N_AX];
    logic              ax_en  [N_AX];
    logic              ax_ok  [N_AX];
    logic              ax_clr [N_AX];
    logic              ax_adv [N_AX];
    logic [SZ_W-1:0]   ax_idx [N_AX];
    logic [PH_W-1:0]   ax_ph  [N_AX];

    // Capture the configuration at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            wh_q   <= '0;
            wv_q   <= '0;
            il_q   <= 1'b0;
            bot_q  <= 1'b0;
        end else if (frame_start) begin
            size_q <= in_size;
            wh_q   <= win_h;
            wv_q   <= win_v;
            il_q   <= interlace;
            bot_q  <= fld_bottom;
        end
    end

    // Unpack sizes and window bounds, halving the vertical window when interlaced.
    always_comb begin
        src_w   = size_q[HI_LSB +: SZ_W] + 1'b1;
        src_h   = size_q[LO_LSB +: SZ_W] + 1'b1;
        hs      = SZ_W'(wh_q[LO_LSB +: CRD_W]);
        he      = SZ_W'(wh_q[HI_LSB +: CRD_W]);
        vs      = SZ_W'(wv_q[LO_LSB +: CRD_W]);
        ve      = SZ_W'(wv_q[HI_LSB +: CRD_W]);
        dst_w   = he - hs + 1'b1;
        dst_hf  = ve - vs + 1'b1;
        vs_f    = il_q ? (vs >> 1) : vs;
        ve_p1   = ve + 1'b1;
        vend_p1 = il_q ? (ve_p1 >> 1) : ve_p1;
        dst_he  = vend_p1 - vs_f;
        ve_f    = vend_p1 - 1'b1;
        rsv_bad = (|(size_q & ~SIZE_MASK)) | (|(wh_q & ~WIN_MASK)) |
                  (|(wv_q & ~WIN_MASK));
        order_bad = (he < hs) || (ve < vs);
    end

    // Route per-axis sizes into the step calculators.
    always_comb begin
        ax_src[AX_H] = src_w;
        ax_dst[AX_H] = dst_w;
        ax_chk[AX_H] = dst_w;
        ax_src[AX_V] = src_h;
        ax_dst[AX_V] = dst_he;
        ax_chk[AX_V] = dst_hf;
    end

    // One step calculator and one accumulator per axis.
    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        scl_step_calc #(
            .SZ_W(SZ_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .MAX_UP(MAX_UP)
        ) u_calc (
            .src_len (ax_src[a]),
            .dst_len (ax_dst[a]),
            .chk_len (ax_chk[a]),
            .step    (ax_step[a]),
            .scale_en(ax_en[a]),
            .range_ok(ax_ok[a])
        );

        scl_axis_acc #(
            .SZ_W(SZ_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .PH_W(PH_W)
        ) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (ax_clr[a]),
            .adv    (ax_adv[a]),
            .step   (ax_step[a]),
            .init   (ax_init[a]),
            .src_len(ax_src[a]),
            .idx    (ax_idx[a]),
            .phase  (ax_ph[a])
        );
    end

    // Track the output pixel and line counts; frame start takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_active <= 1'b0;
            x_cnt       <= '0;
            y_cnt       <= '1;
        end else if (frame_start) begin
            line_active <= line_start;
            x_cnt       <= '0;
            y_cnt       <= line_start ? '0 : '1;
        end else if (line_start) begin
            line_active <= 1'b1;
            x_cnt       <= '0;
            y_cnt       <= (y_cnt == '1) ? '0 :
                           ((y_cnt == SZ_W'({SZ_W{1'b1}} - 1)) ? y_cnt : y_cnt + 1'b1);
        end else begin
            x_cnt       <= (x_cnt == '1) ? x_cnt : x_cnt + 1'b1;
        end
    end

    // Window membership of the current pixel and line.
    always_comb begin
        in_h = (x_cnt >= hs) && (x_cnt <= he);
        in_v = (y_cnt >= vs_f) && (y_cnt <= ve_f);
    end

    // Accumulator control, initial phases and error combination.
    always_comb begin
        ax_clr[AX_H]  = line_start | frame_start;
        ax_adv[AX_H]  = line_active & in_h;
        ax_init[AX_H] = '0;
        ax_clr[AX_V]  = frame_start;
        ax_adv[AX_V]  = line_start & line_active & in_v;
        ax_init[AX_V] = (il_q && bot_q && ax_en[AX_V]) ? (ax_step[AX_V] >> 1) : '0;
        cfg_err       = rsv_bad | order_bad | ~ax_ok[AX_H] | ~ax_ok[AX_V];
    end

    // Drive the outputs.
    always_comb begin
        pix_valid  = line_active & in_h & in_v & ~cfg_err;
        src_x      = ax_idx[AX_H];
        src_y      = ax_idx[AX_V];
        phase_x    = ax_ph[AX_H];
        phase_y    = ax_ph[AX_V];
        h_scale_en = ax_en[AX_H];
        v_scale_en = ax_en[AX_V];
    end

    // R7
    x_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (x_cnt == '0));

    // R9
    joint_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && line_start) |=> (line_active && y_cnt == '0));

    // R3
    h_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !h_scale_en) |-> (phase_x == '0));

    // R3
    v_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !v_scale_en) |-> (phase_y == '0));

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !pix_valid);
endmodule

// File: tb/scl_phase_gen_test.sv
module scl_phase_gen_test;
    localparam int LINE_LEN = 14;
    localparam int N_LINES  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_start = 1'b0;
    logic        interlace = 1'b0;
    logic        fld_bottom = 1'b0;
    logic [31:0] in_size = '0;
    logic [31:0] win_h = '0;
    logic [31:0] win_v = '0;
    logic        pix_valid;
    logic [12:0] src_x, src_y;
    logic [7:0]  phase_x, phase_y;
    logic        h_scale_en, v_scale_en, cfg_err;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R10";
    logic [41:0] exp_q[$];

    always #5 clk = ~clk;

    scl_phase_gen uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .interlace(interlace), .fld_bottom(fld_bottom), .in_size(in_size),
        .win_h(win_h), .win_v(win_v), .pix_valid(pix_valid), .src_x(src_x),
        .src_y(src_y), .phase_x(phase_x), .phase_y(phase_y),
        .h_scale_en(h_scale_en), .v_scale_en(v_scale_en), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expected item for every valid output sample.
    initial begin
        logic [41:0] e, g;
        forever begin
            @(negedge clk);
            if (rst_n && pix_valid) begin
                g = {src_x, src_y, phase_x, phase_y};
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected valid sample", longint'(g), 0);
                end else begin
                    e = exp_q.pop_front();
                    check(g == e, cur_tag, "sample {x,y,px,py}", longint'(g), longint'(e));
                end
            end
        end
    end

    task automatic drive_line();
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (LINE_LEN - 1) @(negedge clk);
    endtask

    // Driver: compute expected raster, push it, then run one frame.
    task automatic run_frame(input int sw, input int sh, input int hs, input int he,
                             input int vs, input int ve, input bit il, input bit bot,
                             input bit joint, input logic [31:0] rsv, input string tag);
        int     dw, dhf, vsf, vep1, dh, first;
        bit     err, hen, ven;
        longint hst, vst, vin, ax, ay, xi, yi;
        dw   = he - hs + 1;
        dhf  = ve - vs + 1;
        vsf  = il ? vs / 2 : vs;
        vep1 = il ? (ve + 1) / 2 : ve + 1;
        dh   = vep1 - vsf;
        err  = (rsv != 0) || (he < hs) || (ve < vs) || (dw < sw) || (dw > 5 * sw) ||
               (dhf < sh) || (dhf > 5 * sh) || (dh <= 0);
        hen  = (sw != dw);
        ven  = (sh != dh);
        hst  = hen ? (longint'(sw) << 24) / dw : (64'd1 << 24);
        vst  = ven ? (longint'(sh) << 24) / ((dh > 0) ? dh : 1) : (64'd1 << 24);
        vin  = (il && bot && ven) ? (vst >> 1) : 0;
        if (!err) begin
            for (int j = 0; j < dh; j++) begin
                for (int i = 0; i < dw; i++) begin
                    ay = vin + j * vst;
                    ax = i * hst;
                    xi = ((ax >> 24) > sw - 1) ? sw - 1 : (ax >> 24);
                    yi = ((ay >> 24) > sh - 1) ? sh - 1 : (ay >> 24);
                    exp_q.push_back({13'(xi), 13'(yi), 8'((ax >> 16) & 255),
                                     8'((ay >> 16) & 255)});
                end
            end
        end
        cur_tag    = tag;
        in_size    = 32'(((sw - 1) << 16) | (sh - 1)) | rsv;
        win_h      = 32'((he << 16) | hs);
        win_v      = 32'((ve << 16) | vs);
        interlace  = il;
        fld_bottom = bot;
        frame_start = 1'b1;
        line_start  = joint;
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
        check(cfg_err == err, tag, "cfg_err", cfg_err, err);
        if (!err) begin
            check(h_scale_en == hen, tag, "h_scale_en", h_scale_en, hen);
            check(v_scale_en == ven, tag, "v_scale_en", v_scale_en, ven);
        end
        if (joint) begin
            repeat (LINE_LEN - 1) @(negedge clk);
            first = 1;
        end else begin
            repeat (2) @(negedge clk);
            first = 0;
        end
        for (int k = first; k < N_LINES; k++) drive_line();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, tag, "samples left after frame", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL %s watchdog actual=%0d expected=%0d", cur_tag, 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pix_valid == 1'b0, "R10", "pix_valid after reset", pix_valid, 0);
        check(cfg_err == 1'b0, "R10", "cfg_err after reset", cfg_err, 0);

        // R1 R7 R8: 2x upscale both axes, progressive
        run_frame(4, 3, 2, 9, 1, 6, 1'b0, 1'b0, 1'b0, 32'h0, "R1");
        // R3: bypass both axes
        run_frame(8, 6, 1, 8, 0, 5, 1'b0, 1'b0, 1'b0, 32'h0, "R3");
        // R1: non-integer steps 3->8 and 2->5
        run_frame(3, 2, 0, 7, 2, 6, 1'b0, 1'b0, 1'b0, 32'h0, "R1");
        // R5: interlaced top field, halved vertical window
        run_frame(4, 3, 2, 9, 1, 12, 1'b1, 1'b0, 1'b0, 32'h0, "R5");
        // R6: interlaced bottom field, half-step initial vertical phase
        run_frame(4, 3, 2, 9, 1, 12, 1'b1, 1'b1, 1'b0, 32'h0, "R6");
        // R6: bottom flag ignored in progressive mode
        run_frame(4, 3, 2, 9, 1, 6, 1'b0, 1'b1, 1'b0, 32'h0, "R6");
        // R2: downscale rejected
        run_frame(8, 3, 0, 3, 0, 5, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
        // R2: beyond five times rejected
        run_frame(2, 2, 0, 10, 0, 1, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
        // R2: exactly five times accepted
        run_frame(2, 2, 0, 9, 0, 9, 1'b0, 1'b0, 1'b0, 32'h0, "R2");
        // R5: interlaced field height of zero rejected
        run_frame(1, 1, 0, 0, 2, 2, 1'b1, 1'b0, 1'b0, 32'h0, "R5");
        // R4: reserved bit set rejected
        run_frame(4, 3, 2, 9, 1, 6, 1'b0, 1'b0, 1'b0, 32'h8000_0000, "R4");
        // R9: joint frame and line strobes, same raster as the first frame
        run_frame(4, 3, 2, 9, 1, 6, 1'b0, 1'b0, 1'b1, 32'h0, "R9");
        // R9: joint strobes on interlaced bottom field
        run_frame(4, 3, 2, 9, 1, 12, 1'b1, 1'b1, 1'b1, 32'h0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule